// File: doc/BRIEF.md
# Packet Auto-Commit Controller

This block sits behind the write side of an inbound FIFO port. An external master presents one entry per clock on a write strobe. The block gathers those entries into packets and hands each finished packet to a small queue of packet buffers, where a consumer drains it one entry at a time. Each entry is a byte or a 16-bit word, depending on a width-select input. The count of a packet is kept in entries of the selected width.

A packet finishes in one of two ways. With automatic commit enabled, the packet is closed on the very edge whose write makes its count equal to a programmable target length. At any time, a packet-end strobe closes whatever has been gathered so far, so short packets, one-entry packets and empty packets can all be sent. All inputs are sampled on the rising clock edge. A packet-end that arrives on the same edge as the write that completes an automatic packet is dropped, and a sticky violation flag is raised. To follow a full automatic packet with a one-entry packet, the master must give the packet-end at least one clock later.

The target length, the commit mode and the entry width are taken from the inputs only while no packet is partly gathered. While every buffer in the queue holds a committed packet, the block refuses writes and packet-end strobes.

Top module: `pkt_autocommit`

## Requirements
- R1: When reset is released, out_valid, q_full and viol are all 0.
- R2: When auto_en is 1, the write that makes the count equal to the target length commits a packet of exactly that many entries. out_valid rises on that same clock edge, and no earlier write commits anything.
- R3: A packet-end strobe commits the gathered entries. A write on the same edge is included, so a write together with a packet-end on an empty packet gives a one-entry packet.
- R4: A packet-end strobe with no gathered entries and no write on that edge commits a packet of length 0. That packet is presented once with out_len = 0 and out_last = 1.
- R5: A packet-end on the same edge as a write that completes an automatic packet produces no extra packet. It also sets viol, and viol stays 1 until reset.
- R6: A write together with a packet-end, given one clock after the edge that completed an automatic packet, commits a separate one-entry packet.
- R7: When auto_en is 0, nothing commits without a packet-end. Once a packet holds MAXLEN entries, further writes are discarded.
- R8: When word_mode is 1, each entry keeps all 16 bits of wr_data and the packet shows out_word = 1. When word_mode is 0, each entry keeps only wr_data[7:0] with the upper byte zero, and the packet shows out_word = 0.
- R9: After NBUF packets are committed and none is drained, q_full is 1. While q_full is 1, writes and packet-end strobes leave no trace in the queue or in the next packet.
- R10: auto_len, auto_en and word_mode are taken only while no entry is gathered. A change in the middle of a packet applies from the next packet. An auto_len of 0, or one above MAXLEN, means MAXLEN.
- R11: Packets leave in commit order, entries in write order. Each handshake (out_valid and out_ready) advances one entry. out_last marks the final entry, and the handshake on that entry moves to the next packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one entry per cycle |
| wr_data | input | 16 | Entry data; low byte only in byte mode |
| pkt_end | input | 1 | Commit the gathered entries now |
| auto_en | input | 1 | 1 = commit automatically at the target length |
| word_mode | input | 1 | 1 = 16-bit entries, 0 = byte entries |
| auto_len | input | $clog2(MAXLEN+1) | Target length in entries (0 means MAXLEN) |
| out_valid | output | 1 | Head packet has an entry (or an empty packet) to offer |
| out_ready | input | 1 | Consumer takes the offered entry |
| out_data | output | 16 | Offered entry |
| out_len | output | $clog2(MAXLEN+1) | Length of the head packet in entries |
| out_word | output | 1 | Entry width of the head packet |
| out_last | output | 1 | Offered entry is the last of its packet |
| q_full | output | 1 | Every packet buffer holds a committed packet |
| viol | output | 1 | Sticky: packet-end collided with an automatic commit |

## Verification
If the fill counter drifts, the fault shows on the edge of the expected commit: out_valid rises one write early or late, and the drained out_len differs from the number of entries written. If the held configuration is wrong, a packet whose target length changed midway closes at the new length, so the mistake is visible before the packet is drained. If the queue pointers are wrong, the next handshake returns stale or reordered data, and q_full does not match the number of commits minus drains. A lost collision flag shows as viol still 0 on the cycle after the colliding edge.

// File: rtl/pkc_pkg.sv
package pkc_pkg;

    typedef struct packed {
        logic auto_en;
        logic word_mode;
    } pkc_mode_t;

    typedef enum logic [1:0] {
        CM_NONE = 2'd0,
        CM_AUTO = 2'd1,
        CM_PEND = 2'd2
    } pkc_cause_t;

    // Target length with 0 or out-of-range values mapped to the maximum
    function automatic int unsigned pkc_clamp_len(input int unsigned req,
                                                  input int unsigned maxlen);
        if (req == 0 || req > maxlen) return maxlen;
        return req;
    endfunction

endpackage

// File: rtl/pkc_framer.sv
module pkc_framer
    import pkc_pkg::*;
#(
    parameter int unsigned MAXLEN = 16,
    parameter int unsigned CW     = $clog2(MAXLEN + 1),
    parameter int unsigned IW     = $clog2(MAXLEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          pkt_end,
    input  logic          q_full,
    input  logic          auto_en_in,
    input  logic          word_in,
    input  logic [CW-1:0] auto_len_in,
    output logic          acc_we,
    output logic [IW-1:0] acc_idx,
    output logic          acc_word,
    output logic          commit,
    output logic [CW-1:0] commit_len,
    output logic          viol
);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_n;
    logic [CW-1:0] held_len;
    logic [CW-1:0] eff_len;
    pkc_mode_t     held_mode;
    pkc_mode_t     eff_mode;
    pkc_cause_t    cause;
    logic          idle;
    logic          wr_ok;
    logic          pe_ok;
    logic          auto_hit;

    // Configuration is live only between packets, held otherwise
    assign idle = (cnt == '0);

    always_comb begin
        if (idle) begin
            eff_mode.auto_en   = auto_en_in;
            eff_mode.word_mode = word_in;
            eff_len            = CW'(pkc_clamp_len(int'(auto_len_in), MAXLEN));
        end else begin
            eff_mode = held_mode;
            eff_len  = held_len;
        end
    end

    assign wr_ok    = wr_en && !q_full && (cnt < CW'(MAXLEN));
    assign pe_ok    = pkt_end && !q_full;
    assign cnt_n    = cnt + CW'(wr_ok);
    assign auto_hit = eff_mode.auto_en && wr_ok && (cnt_n == eff_len);

    always_comb begin
        if (auto_hit)   cause = CM_AUTO;
        else if (pe_ok) cause = CM_PEND;
        else            cause = CM_NONE;
    end

    assign acc_we     = wr_ok;
    assign acc_idx    = cnt[IW-1:0];
    assign acc_word   = eff_mode.word_mode;
    assign commit     = (cause != CM_NONE);
    assign commit_len = cnt_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            held_len  <= '0;
            held_mode <= '0;
            viol      <= 1'b0;
        end else begin
            held_len  <= eff_len;
            held_mode <= eff_mode;
            cnt       <= commit ? '0 : cnt_n;
            if (cause == CM_AUTO && pkt_end) viol <= 1'b1;
        end
    end

endmodule

// File: rtl/pkc_pktq.sv
module pkc_pktq #(
    parameter int unsigned DW     = 16,
    parameter int unsigned MAXLEN = 16,
    parameter int unsigned NBUF   = 4,
    parameter int unsigned CW     = $clog2(MAXLEN + 1),
    parameter int unsigned IW     = $clog2(MAXLEN),
    parameter int unsigned PW     = $clog2(NBUF),
    parameter int unsigned QW     = $clog2(NBUF + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_we,
    input  logic [IW-1:0] acc_idx,
    input  logic [DW-1:0] acc_data,
    input  logic          commit,
    input  logic [CW-1:0] commit_len,
    input  logic          commit_word,
    output logic          q_full,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic [CW-1:0] out_len,
    output logic          out_word,
    output logic          out_last
);

    logic [DW-1:0] mem      [NBUF][MAXLEN];
    logic [CW-1:0] slot_len [NBUF];
    logic          slot_wd  [NBUF];
    logic [PW-1:0] wp;
    logic [PW-1:0] rp;
    logic [QW-1:0] qcnt;
    logic [CW-1:0] rd_idx;
    logic          pop;
    logic          pop_pkt;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(NBUF - 1)) ? '0 : p + 1'b1;
    endfunction

    assign q_full    = (qcnt == QW'(NBUF));
    assign out_valid = (qcnt != '0);
    assign out_len   = slot_len[rp];
    assign out_word  = slot_wd[rp];
    assign out_data  = mem[rp][rd_idx[IW-1:0]];
    assign out_last  = out_valid &&
                       ((out_len == '0) || (rd_idx == out_len - 1'b1));
    assign pop       = out_valid && out_ready;
    assign pop_pkt   = pop && out_last;

    always_ff @(posedge clk) begin
        if (acc_we) mem[wp][acc_idx] <= acc_data;
        if (commit) begin
            slot_len[wp] <= commit_len;
            slot_wd[wp]  <= commit_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp     <= '0;
            rp     <= '0;
            qcnt   <= '0;
            rd_idx <= '0;
        end else begin
            if (commit) wp <= nxt(wp);
            if (pop_pkt) begin
                rp     <= nxt(rp);
                rd_idx <= '0;
            end else if (pop) begin
                rd_idx <= rd_idx + 1'b1;
            end
            case ({commit, pop_pkt})
                2'b10:   qcnt <= qcnt + 1'b1;
                2'b01:   qcnt <= qcnt - 1'b1;
                default: qcnt <= qcnt;
            endcase
        end
    end

endmodule

// File: rtl/pkt_autocommit.sv
module pkt_autocommit #(
    parameter int unsigned BW     = 8,
    parameter int unsigned MAXLEN = 16,
    parameter int unsigned NBUF   = 4,
    localparam int unsigned DW    = 2 * BW,
    localparam int unsigned CW    = $clog2(MAXLEN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          pkt_end,
    input  logic          auto_en,
    input  logic          word_mode,
    input  logic [CW-1:0] auto_len,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic [CW-1:0] out_len,
    output logic          out_word,
    output logic          out_last,
    output logic          q_full,
    output logic          viol
);

    localparam int unsigned IW = $clog2(MAXLEN);

    logic          acc_we;
    logic [IW-1:0] acc_idx;
    logic          acc_word;
    logic [DW-1:0] acc_data;
    logic          commit;
    logic [CW-1:0] commit_len;

    assign acc_data = acc_word ? wr_data : {{BW{1'b0}}, wr_data[BW-1:0]};

    pkc_framer #(.MAXLEN(MAXLEN), .CW(CW), .IW(IW)) u_framer (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .pkt_end     (pkt_end),
        .q_full      (q_full),
        .auto_en_in  (auto_en),
        .word_in     (word_mode),
        .auto_len_in (auto_len),
        .acc_we      (acc_we),
        .acc_idx     (acc_idx),
        .acc_word    (acc_word),
        .commit      (commit),
        .commit_len  (commit_len),
        .viol        (viol)
    );

    pkc_pktq #(.DW(DW), .MAXLEN(MAXLEN), .NBUF(NBUF), .CW(CW), .IW(IW)) u_queue (
        .clk         (clk),
        .rst         (rst),
        .acc_we      (acc_we),
        .acc_idx     (acc_idx),
        .acc_data    (acc_data),
        .commit      (commit),
        .commit_len  (commit_len),
        .commit_word (acc_word),
        .q_full      (q_full),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_data    (out_data),
        .out_len     (out_len),
        .out_word    (out_word),
        .out_last    (out_last)
    );

endmodule

// File: rtl/pkt_autocommit_chk.sv
module pkt_autocommit_chk #(
    parameter int unsigned DW     = 16,
    parameter int unsigned MAXLEN = 16,
    parameter int unsigned CW     = $clog2(MAXLEN + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          pkt_end,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_data,
    input logic [CW-1:0] out_len,
    input logic          out_last,
    input logic          q_full,
    input logic          viol
);

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!out_valid && !q_full && !viol));

    a_r5_viol_sticky: assert property (@(posedge clk) disable iff (rst)
        viol |=> viol);

    a_r5_viol_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(viol) |-> ($past(pkt_end) && $past(wr_en)));

    a_r4_empty_is_last: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_len == '0) |-> out_last);

    a_r7_len_bound: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_len <= CW'(MAXLEN)));

    a_r9_full_has_head: assert property (@(posedge clk) disable iff (rst)
        q_full |-> out_valid);

    a_r9_full_holds: assert property (@(posedge clk) disable iff (rst)
        (q_full && !out_ready) |=> q_full);

    a_r11_hold_offer: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_len)));

endmodule

bind pkt_autocommit pkt_autocommit_chk #(.DW(DW), .MAXLEN(MAXLEN), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .pkt_end   (pkt_end),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_len   (out_len),
    .out_last  (out_last),
    .q_full    (q_full),
    .viol      (viol)
);

// File: tb/tb_pkt_autocommit.sv
module tb_pkt_autocommit;

    localparam int MAXLEN = 16;
    localparam int NBUF   = 4;
    localparam int CW     = $clog2(MAXLEN + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [15:0]   wr_data = '0;
    logic          pkt_end = 1'b0;
    logic          auto_en = 1'b0;
    logic          word_mode = 1'b0;
    logic [CW-1:0] auto_len = '0;
    logic          out_ready = 1'b0;
    logic          out_valid;
    logic [15:0]   out_data;
    logic [CW-1:0] out_len;
    logic          out_word;
    logic          out_last;
    logic          q_full;
    logic          viol;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    pkt_autocommit #(.BW(8), .MAXLEN(MAXLEN), .NBUF(NBUF)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .pkt_end(pkt_end), .auto_en(auto_en), .word_mode(word_mode),
        .auto_len(auto_len), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_len(out_len), .out_word(out_word),
        .out_last(out_last), .q_full(q_full), .viol(viol)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    task automatic cyc(input logic we, input logic [15:0] d, input logic pe);
        wr_en = we; wr_data = d; pkt_end = pe;
        @(posedge clk); #1;
        wr_en = 1'b0; pkt_end = 1'b0;
    endtask

    function automatic logic [15:0] expv(input logic [15:0] base, input int i,
                                         input bit wd);
        logic [15:0] v;
        v = base + 16'(i);
        return wd ? v : {8'h00, v[7:0]};
    endfunction

    // Drain one packet and compare every entry with the written pattern
    task automatic pop_pkt(input string req, input int len, input bit wd,
                           input logic [15:0] base);
        int n;
        n = (len == 0) ? 1 : len;
        for (int i = 0; i < n; i++) begin
            check(req, "out_valid", 32'(out_valid), 1);
            check(req, "out_len", 32'(out_len), 32'(len));
            check(req, "out_word", 32'(out_word), 32'(wd));
            check(req, "out_last", 32'(out_last), 32'(i == n - 1));
            if (len != 0) check(req, "out_data", 32'(out_data), 32'(expv(base, i, wd)));
            out_ready = 1'b1;
            @(posedge clk); #1;
            out_ready = 1'b0;
        end
    endtask

    task automatic t_reset();
        check("R1", "out_valid", 32'(out_valid), 0);
        check("R1", "q_full", 32'(q_full), 0);
        check("R1", "viol", 32'(viol), 0);
    endtask

    task automatic t_auto_byte();
        auto_en = 1; word_mode = 0; auto_len = CW'(4);
        for (int i = 0; i < 3; i++) cyc(1, 16'h12F0 + 16'(i), 0);
        check("R2", "no commit before target", 32'(out_valid), 0);
        cyc(1, 16'h12F3, 0);
        check("R2", "commit at target", 32'(out_valid), 1);
        pop_pkt("R8", 4, 0, 16'h12F0);
        check("R11", "drained", 32'(out_valid), 0);
    endtask

    task automatic t_short_and_empty();
        auto_en = 0; word_mode = 1;
        cyc(1, 16'hBEEF, 1);
        pop_pkt("R3", 1, 1, 16'hBEEF);
        cyc(0, 16'h0, 1);
        pop_pkt("R4", 0, 1, 16'h0);
        check("R4", "single empty packet", 32'(out_valid), 0);
    endtask

    task automatic t_collision();
        auto_en = 1; word_mode = 1; auto_len = CW'(3);
        cyc(1, 16'h7000, 0);
        cyc(1, 16'h7001, 0);
        cyc(1, 16'h7002, 1);
        check("R5", "viol set", 32'(viol), 1);
        pop_pkt("R5", 3, 1, 16'h7000);
        check("R5", "no extra packet", 32'(out_valid), 0);
        // full packet then one-entry packet one clock later
        cyc(1, 16'h8100, 0);
        cyc(1, 16'h8101, 0);
        cyc(1, 16'h8102, 0);
        cyc(1, 16'h8A00, 1);
        pop_pkt("R6", 3, 1, 16'h8100);
        pop_pkt("R6", 1, 1, 16'h8A00);
        check("R5", "viol sticky", 32'(viol), 1);
    endtask

    task automatic t_manual_cap();
        auto_en = 0; word_mode = 1; auto_len = CW'(4);
        for (int i = 0; i < 5; i++) cyc(1, 16'h3300 + 16'(i), 0);
        check("R7", "no auto commit", 32'(out_valid), 0);
        for (int i = 5; i < 20; i++) cyc(1, 16'h3300 + 16'(i), 0);
        cyc(0, 16'h0, 1);
        pop_pkt("R7", MAXLEN, 1, 16'h3300);
    endtask

    task automatic t_latch();
        auto_en = 1; word_mode = 1; auto_len = CW'(4);
        cyc(1, 16'h4400, 0);
        cyc(1, 16'h4401, 0);
        auto_len = CW'(2);
        cyc(1, 16'h4402, 0);
        check("R10", "held length", 32'(out_valid), 0);
        cyc(1, 16'h4403, 0);
        check("R10", "commit at held length", 32'(out_valid), 1);
        pop_pkt("R10", 4, 1, 16'h4400);
        cyc(1, 16'h4500, 0);
        cyc(1, 16'h4501, 0);
        pop_pkt("R10", 2, 1, 16'h4500);
        auto_len = '0;
        for (int i = 0; i < 15; i++) cyc(1, 16'h4600 + 16'(i), 0);
        check("R10", "zero means max", 32'(out_valid), 0);
        cyc(1, 16'h460F, 0);
        pop_pkt("R10", MAXLEN, 1, 16'h4600);
    endtask

    task automatic t_full();
        auto_en = 0; word_mode = 1;
        for (int k = 0; k < NBUF; k++) cyc(1, 16'h0B00 + 16'(k), 1);
        check("R9", "q_full", 32'(q_full), 1);
        cyc(1, 16'hDEAD, 1);
        check("R9", "still full", 32'(q_full), 1);
        for (int k = 0; k < NBUF; k++) pop_pkt("R11", 1, 1, 16'h0B00 + 16'(k));
        check("R9", "nothing extra queued", 32'(out_valid), 0);
        cyc(0, 16'h0, 1);
        pop_pkt("R9", 0, 1, 16'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_auto_byte();
        t_short_and_empty();
        t_collision();
        t_manual_cap();
        t_latch();
        t_full();
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule